// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is a general-purpose timer built around a prescaler, a counter and an auto-reload limit. The counter can run in edge-aligned mode, counting up or down, or in three center-aligned modes that sweep up and then back down. Each wrap produces an update event. That event copies the buffered reload limit, the prescaler divisor and the compare value into the working (shadow) copies. The timer exposes three one-cycle strobes: the update event, an update interrupt request and a compare match.

All configuration goes through a single write port with a 3-bit select. Select 0 writes the control byte. Select 1 writes the reload limit, select 2 the prescaler divisor and select 3 the compare value. Select 4 writes the event byte, whose bit 0 requests a software update. Other select codes do nothing.

A separate `slave_rst_i` input lets a neighbouring controller restart the count. The control byte reads back on `ctrl_o`, so software and the surrounding logic can see when one-pulse mode has stopped the timer.

Top module: `updn_tmr_core`

## Requirements
- R1: After reset the control byte, the counter, the direction output and all three strobes are 0. All preload and shadow values are also 0.
- R2: The control byte has this layout:
  - bit 0 enable
  - bit 1 update freeze
  - bit 2 interrupt source filter
  - bit 3 one-pulse
  - bit 4 direction (1 = down)
  - bits 6:5 alignment mode
  - bit 7 reload buffering

  With mode 00 and enable set, the counter steps once every PSC+1 clock cycles. Counting up, it goes from the reload limit to 0 with an overflow. Counting down, it goes from 0 to the reload limit with an underflow. Otherwise it steps by one.
- R3: In modes 01, 10 and 11 the counter sweeps as follows:
  - It rises to the reload limit. The step that reaches the limit is an overflow and turns the direction down.
  - It falls to 0. The step that reaches 0 is an underflow and turns the direction up.
  - `dir_o` shows the current sweep direction.
  - With a reload limit of 0 the counter holds.
- R4: `cmp_flag_o` pulses after a counter step whose new value equals the compare shadow, gated by mode:
  - Mode 00 and mode 11: the flag is allowed on any step.
  - Mode 01: the flag is allowed only on down steps.
  - Mode 10: the flag is allowed only on up steps.
- R5: With one-pulse set, an update event clears the enable bit in the same clock edge that applies the wrap. The counter then stays where it wrapped to.
- R6: Overflow and underflow always raise the interrupt, provided an update event occurs. With the source filter at 0, a software update or a slave reset also raises it. With the filter at 1, they do not.
- R7: With update freeze set, no update event and no interrupt occur, and the shadow copies keep their values. A software update or a slave reset still reinitializes the counter and the prescaler.
- R8: With reload buffering at 0, a written reload limit is used from the next cycle. With buffering at 1, it is used only after the next update event.
- R9: A control write that would move the mode from 00 to a non-zero mode while enable is 1 keeps mode 00. The other bits of that write still apply.
- R10: Writing 1 to bit 0 of the event byte (select 4) requests a software update, which acts in the following cycle and then clears itself. It resets the prescaler count and sets the counter to 0, or to the reload limit when the mode is 00 and the direction is down. If an update event occurs at the same time, it is the newly loaded limit that is used.
- R11: A high cycle on `slave_rst_i` reinitializes the counter and the prescaler in the same way as a software update, and counts as an update source.
- R12: The prescaler divisor and the compare value take effect only through their shadows, which load on an update event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Write target: 0 control, 1 reload, 2 prescaler, 3 compare, 4 event |
| wr_data_i | input | DATA_W | Write data |
| slave_rst_i | input | 1 | Counter restart from a neighbouring controller |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current counting direction, 1 = down |
| ctrl_o | output | 8 | Control byte |
| upd_evt_o | output | 1 | Update event strobe |
| upd_irq_o | output | 1 | Update interrupt request strobe |
| cmp_flag_o | output | 1 | Compare match strobe |

## Verification
A wrong prescaler count or a wrong divisor shadow shows up as a counter step a cycle early or late. That is visible on `cnt_o` within one prescaled period. A stale reload or compare shadow shows up at the next wrap or match: the counter wraps at the wrong value, or a strobe fires or stays silent on a step where the mode gating says otherwise. A wrong sweep direction flips `dir_o` at once and misplaces the next update event. The bench compares every output against a behavioural model on every cycle, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    typedef struct packed {
        logic       arbuf;
        logic [1:0] cmode;
        logic       dir;
        logic       opm;
        logic       urs;
        logic       udis;
        logic       en;
    } tmr_ctrl_t;

    localparam logic [1:0] CM_EDGE = 2'b00;
    localparam logic [1:0] CM_DOWN = 2'b01;
    localparam logic [1:0] CM_UP   = 2'b10;
    localparam logic [1:0] CM_BOTH = 2'b11;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_RELOAD = 3'd1;
    localparam logic [2:0] SEL_PRESC  = 3'd2;
    localparam logic [2:0] SEL_CMP    = 3'd3;
    localparam logic [2:0] SEL_EVT    = 3'd4;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [PSC_W-1:0] limit_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            if (st_q.cnt >= limit_i) begin
                tick_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R7 / R10: a reinit request leaves the prescale count at zero
    a_r10_psc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_arr_i,
    input  logic              wr_psc_i,
    input  logic              wr_cmp_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_i,
    input  logic              arbuf_i,
    input  logic              reinit_loads_i,
    output logic [CNT_W-1:0]  arr_eff_o,
    output logic [CNT_W-1:0]  arr_init_o,
    output logic [PSC_W-1:0]  psc_act_o,
    output logic [CNT_W-1:0]  cmp_act_o
);

    typedef struct packed {
        logic [CNT_W-1:0] arr_pre;
        logic [CNT_W-1:0] arr_sh;
        logic [PSC_W-1:0] psc_pre;
        logic [PSC_W-1:0] psc_sh;
        logic [CNT_W-1:0] cmp_pre;
        logic [CNT_W-1:0] cmp_sh;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.arr_sh = st_q.arr_pre;
            st_d.psc_sh = st_q.psc_pre;
            st_d.cmp_sh = st_q.cmp_pre;
        end
        if (wr_arr_i) st_d.arr_pre = wr_data_i[CNT_W-1:0];
        if (wr_psc_i) st_d.psc_pre = wr_data_i[PSC_W-1:0];
        if (wr_cmp_i) st_d.cmp_pre = wr_data_i[CNT_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign arr_eff_o  = arbuf_i ? st_q.arr_sh : st_q.arr_pre;
    assign arr_init_o = reinit_loads_i ? st_q.arr_pre : arr_eff_o;
    assign psc_act_o  = st_q.psc_sh;
    assign cmp_act_o  = st_q.cmp_sh;

    // R12: the working divisor moves only on an update event
    a_r12_psc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> (psc_act_o == $past(psc_act_o)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             reinit_i,
    input  logic [1:0]       cmode_i,
    input  logic             dir_bit_i,
    input  logic [CNT_W-1:0] arr_eff_i,
    input  logic [CNT_W-1:0] arr_init_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             wrap_o,
    output logic             cmp_hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step_dn;
    logic    stepped;
    logic    gate;

    always_comb begin
        st_d    = st_q;
        wrap_o  = 1'b0;
        step_dn = 1'b0;
        stepped = 1'b0;
        if (reinit_i) begin
            st_d.cnt  = (cmode_i == CM_EDGE && dir_bit_i) ? arr_init_i : '0;
            st_d.down = 1'b0;
        end else if (tick_i) begin
            stepped = 1'b1;
            if (cmode_i == CM_EDGE) begin
                if (!dir_bit_i) begin
                    if (st_q.cnt >= arr_eff_i) begin
                        st_d.cnt = '0;
                        wrap_o   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    step_dn = 1'b1;
                    if (st_q.cnt == '0) begin
                        st_d.cnt = arr_eff_i;
                        wrap_o   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end else if (arr_eff_i != '0) begin
                if (!st_q.down) begin
                    if (st_q.cnt >= arr_eff_i - 1'b1) begin
                        st_d.cnt  = arr_eff_i;
                        st_d.down = 1'b1;
                        wrap_o    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    step_dn = 1'b1;
                    if (st_q.cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                        st_d.cnt  = '0;
                        st_d.down = 1'b0;
                        wrap_o    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
        end
        if (cmode_i == CM_EDGE) st_d.down = 1'b0;

        unique case (cmode_i)
            CM_DOWN: gate = step_dn;
            CM_UP:   gate = !step_dn;
            default: gate = 1'b1;
        endcase
        cmp_hit_o = stepped && (st_d.cnt == cmp_val_i) && gate;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign dir_o = (cmode_i == CM_EDGE) ? dir_bit_i : st_q.down;

    // R2: an up step below the limit advances by exactly one
    a_r2_edge_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !reinit_i && cmode_i == CM_EDGE && !dir_bit_i && st_q.cnt < arr_eff_i)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R3: the bottom of a downward sweep lands on zero and turns upward
    a_r3_center_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !reinit_i && cmode_i != CM_EDGE && st_q.down && arr_eff_i != '0
         && st_q.cnt <= {{(CNT_W-1){1'b0}}, 1'b1})
        |=> (st_q.cnt == '0 && !st_q.down));

    // R11: a restart outside edge-down counting returns the counter to zero
    a_r11_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reinit_i && !(cmode_i == CM_EDGE && dir_bit_i)) |=> (st_q.cnt == '0));

endmodule

// File: rtl/updn_tmr_core.sv
module updn_tmr_core
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              slave_rst_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_o,
    output logic [7:0]        ctrl_o,
    output logic              upd_evt_o,
    output logic              upd_irq_o,
    output logic              cmp_flag_o
);

    typedef struct packed {
        tmr_ctrl_t ctrl;
        logic      ug;
        logic      evt;
        logic      irq;
        logic      cmp;
    } top_st_t;

    top_st_t    st_d, st_q;
    tmr_ctrl_t  wr_ctrl;
    logic       reinit;
    logic       tick;
    logic       wrap;
    logic       cmp_hit;
    logic       uev;
    logic       irq;
    logic [CNT_W-1:0] arr_eff;
    logic [CNT_W-1:0] arr_init;
    logic [CNT_W-1:0] cmp_act;
    logic [PSC_W-1:0] psc_act;

    assign reinit = st_q.ug | slave_rst_i;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.ctrl.en),
        .clear_i (reinit),
        .limit_i (psc_act),
        .tick_o  (tick)
    );

    tmr_shadow #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_shd (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .wr_arr_i       (wr_en_i && wr_sel_i == SEL_RELOAD),
        .wr_psc_i       (wr_en_i && wr_sel_i == SEL_PRESC),
        .wr_cmp_i       (wr_en_i && wr_sel_i == SEL_CMP),
        .wr_data_i      (wr_data_i),
        .load_i         (uev),
        .arbuf_i        (st_q.ctrl.arbuf),
        .reinit_loads_i (!st_q.ctrl.udis),
        .arr_eff_o      (arr_eff),
        .arr_init_o     (arr_init),
        .psc_act_o      (psc_act),
        .cmp_act_o      (cmp_act)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .reinit_i   (reinit),
        .cmode_i    (st_q.ctrl.cmode),
        .dir_bit_i  (st_q.ctrl.dir),
        .arr_eff_i  (arr_eff),
        .arr_init_i (arr_init),
        .cmp_val_i  (cmp_act),
        .cnt_o      (cnt_o),
        .dir_o      (dir_o),
        .wrap_o     (wrap),
        .cmp_hit_o  (cmp_hit)
    );

    always_comb begin
        st_d = st_q;
        uev  = !st_q.ctrl.udis && (wrap || reinit);
        irq  = uev && (wrap || !st_q.ctrl.urs);

        wr_ctrl = tmr_ctrl_t'(wr_data_i[7:0]);
        if (st_q.ctrl.en && st_q.ctrl.cmode == CM_EDGE && wr_ctrl.cmode != CM_EDGE)
            wr_ctrl.cmode = st_q.ctrl.cmode;
        if (wr_en_i && wr_sel_i == SEL_CTRL) st_d.ctrl = wr_ctrl;
        if (uev && st_q.ctrl.opm) st_d.ctrl.en = 1'b0;

        st_d.ug  = wr_en_i && wr_sel_i == SEL_EVT && wr_data_i[0];
        st_d.evt = uev;
        st_d.irq = irq;
        st_d.cmp = cmp_hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o     = st_q.ctrl;
    assign upd_evt_o  = st_q.evt;
    assign upd_irq_o  = st_q.irq;
    assign cmp_flag_o = st_q.cmp;

    // R9: a running edge-aligned timer cannot be switched to center mode
    a_r9_mode_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_CTRL && st_q.ctrl.en && st_q.ctrl.cmode == CM_EDGE)
        |=> (ctrl_o[6:5] == CM_EDGE));

    // R5: one-pulse operation drops enable with the update
    a_r5_opm_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uev && st_q.ctrl.opm) |=> !ctrl_o[0]);

    // R7: frozen updates never show a strobe
    a_r7_freeze_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ctrl.udis |=> !upd_evt_o);

    // R6: an interrupt is always part of an update event
    a_r6_irq_in_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_irq_o |-> upd_evt_o);

    // R6: with the source filter on, only a wrap may raise the interrupt
    a_r6_urs_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctrl.urs && !wrap) |=> !upd_irq_o);

    // R4: up-only gating keeps the flag quiet during down sweeps
    a_r4_up_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctrl.cmode == CM_UP && dir_o) |=> !cmp_flag_o);

endmodule

// File: tb/updn_tmr_core_tb.sv
`timescale 1ns/1ps
module updn_tmr_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic        slave_rst = 1'b0;
    logic [15:0] cnt_o;
    logic        dir_o;
    logic [7:0]  ctrl_o;
    logic        upd_evt_o, upd_irq_o, cmp_flag_o;

    always #4 clk = ~clk;

    updn_tmr_core u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .slave_rst_i(slave_rst), .cnt_o(cnt_o),
        .dir_o(dir_o), .ctrl_o(ctrl_o), .upd_evt_o(upd_evt_o),
        .upd_irq_o(upd_irq_o), .cmp_flag_o(cmp_flag_o)
    );

    int    nchk = 0;
    int    nerr = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string phase = "R1";

    // behavioural reference state
    int m_en, m_udis, m_urs, m_opm, m_dir, m_cm, m_arb;
    int m_arrp, m_arrs, m_pscp, m_pscs, m_cmpp, m_cmps;
    int m_cnt, m_cdn, m_psc, m_ug, m_evt, m_irq, m_cmpf;
    int arre, arr_init, nc, ndn, ncm, old_opm, dw;
    bit reinit, tick, wrap, sdn, gate, hit, uev, irq;

    task automatic chk(input string req, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_udis = 0; m_urs = 0; m_opm = 0; m_dir = 0; m_cm = 0; m_arb = 0;
            m_arrp = 0; m_arrs = 0; m_pscp = 0; m_pscs = 0; m_cmpp = 0; m_cmps = 0;
            m_cnt = 0; m_cdn = 0; m_psc = 0; m_ug = 0; m_evt = 0; m_irq = 0; m_cmpf = 0;
        end else begin
            arre     = m_arb ? m_arrs : m_arrp;
            reinit   = (m_ug != 0) || slave_rst;
            arr_init = m_udis ? arre : m_arrp;
            tick     = m_en && !reinit && (m_psc >= m_pscs);
            wrap = 0; sdn = 0; nc = m_cnt; ndn = m_cdn;
            if (reinit) begin
                nc  = (m_cm == 0 && m_dir) ? arr_init : 0;
                ndn = 0;
            end else if (tick) begin
                if (m_cm == 0) begin
                    if (!m_dir) begin
                        if (m_cnt >= arre) begin nc = 0; wrap = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        sdn = 1;
                        if (m_cnt == 0) begin nc = arre; wrap = 1; end
                        else nc = m_cnt - 1;
                    end
                end else if (arre != 0) begin
                    if (!m_cdn) begin
                        if (m_cnt >= arre - 1) begin nc = arre; ndn = 1; wrap = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        sdn = 1;
                        if (m_cnt <= 1) begin nc = 0; ndn = 0; wrap = 1; end
                        else nc = m_cnt - 1;
                    end
                end
            end
            if (m_cm == 0) ndn = 0;
            gate = (m_cm == 1) ? sdn : (m_cm == 2) ? !sdn : 1'b1;
            hit  = tick && (nc == m_cmps) && gate;
            uev  = !m_udis && (wrap || reinit);
            irq  = uev && (wrap || !m_urs);
            if (reinit) m_psc = 0;
            else if (m_en) m_psc = (m_psc >= m_pscs) ? 0 : m_psc + 1;
            if (uev) begin m_arrs = m_arrp; m_pscs = m_pscp; m_cmps = m_cmpp; end
            old_opm = m_opm;
            dw = int'(wr_data);
            if (wr_en && wr_sel == 3'd1) m_arrp = dw;
            if (wr_en && wr_sel == 3'd2) m_pscp = dw;
            if (wr_en && wr_sel == 3'd3) m_cmpp = dw;
            if (wr_en && wr_sel == 3'd0) begin
                ncm = (dw >> 5) & 3;
                if (m_en && m_cm == 0 && ncm != 0) ncm = m_cm;
                m_en = dw & 1; m_udis = (dw >> 1) & 1; m_urs = (dw >> 2) & 1;
                m_opm = (dw >> 3) & 1; m_dir = (dw >> 4) & 1; m_cm = ncm;
                m_arb = (dw >> 7) & 1;
            end
            if (uev && old_opm) m_en = 0;
            m_ug = (wr_en && wr_sel == 3'd4 && wr_data[0]) ? 1 : 0;
            m_cnt = nc; m_cdn = ndn;
            m_evt = uev; m_irq = irq; m_cmpf = hit;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(phase, "cnt_o", int'(cnt_o), m_cnt);
            chk(phase, "dir_o", int'(dir_o), (m_cm == 0) ? m_dir : m_cdn);
            chk(phase, "ctrl_o", int'(ctrl_o),
                m_en | (m_udis << 1) | (m_urs << 2) | (m_opm << 3) | (m_dir << 4)
                | (m_cm << 5) | (m_arb << 7));
            chk(phase, "upd_evt_o", int'(upd_evt_o), m_evt);
            chk(phase, "upd_irq_o", int'(upd_irq_o), m_irq);
            chk(phase, "cmp_flag_o", int'(cmp_flag_o), m_cmpf);
        end
    end

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick_slave();
        @(negedge clk);
        slave_rst = 1'b1;
        @(negedge clk);
        slave_rst = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);
        // R1: reset values seen at the ports
        chk("R1", "ctrl_o", int'(ctrl_o), 0);
        chk("R1", "cnt_o", int'(cnt_o), 0);
        chk("R1", "upd_evt_o", int'(upd_evt_o), 0);

        phase = "R10";
        wr(3'd2, 16'd1); wr(3'd1, 16'd5); wr(3'd4, 16'd1); idle(3);

        phase = "R2";
        wr(3'd0, 16'h01); idle(30);
        wr(3'd0, 16'h11); idle(30);

        phase = "R9";
        wr(3'd0, 16'h01); wr(3'd0, 16'h21);
        chk("R9", "ctrl_o mode kept", int'(ctrl_o), 8'h01);

        phase = "R3";
        wr(3'd0, 16'h00); wr(3'd3, 16'd2); wr(3'd4, 16'd1);
        wr(3'd0, 16'h60); wr(3'd0, 16'h61); idle(40);

        phase = "R4";
        wr(3'd0, 16'h60); wr(3'd0, 16'h20); wr(3'd0, 16'h21); idle(30);
        wr(3'd0, 16'h20); wr(3'd0, 16'h40); wr(3'd0, 16'h41); idle(30);
        wr(3'd0, 16'h00);

        phase = "R8";
        wr(3'd2, 16'd0); wr(3'd4, 16'd1); wr(3'd0, 16'h81); idle(5);
        wr(3'd1, 16'd2); idle(20);
        wr(3'd0, 16'h01); wr(3'd1, 16'd7); idle(20);

        phase = "R12";
        wr(3'd2, 16'd2); wr(3'd3, 16'd4); idle(20);
        wr(3'd4, 16'd1); idle(25);

        phase = "R6";
        wr(3'd0, 16'h05); wr(3'd4, 16'd1); idle(3);
        wr(3'd0, 16'h01); wr(3'd4, 16'd1); idle(5);

        phase = "R7";
        wr(3'd0, 16'h83); wr(3'd1, 16'd3); wr(3'd2, 16'd0);
        wr(3'd4, 16'd1); idle(20);
        wr(3'd0, 16'h81); idle(20);

        phase = "R11";
        kick_slave(); idle(4);
        wr(3'd0, 16'h05); kick_slave(); idle(4);
        wr(3'd0, 16'h11); kick_slave(); idle(6);

        phase = "R5";
        wr(3'd0, 16'h00); wr(3'd1, 16'd3); wr(3'd2, 16'd0); wr(3'd4, 16'd1);
        wr(3'd0, 16'h09); idle(20);
        chk("R5", "ctrl_o enable", int'(ctrl_o[0]), 0);
        chk("R5", "cnt_o stopped", int'(cnt_o), 0);

        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr_en     = ($urandom_range(0, 3) == 0);
            wr_sel    = 3'($urandom_range(0, 5));
            slave_rst = ($urandom_range(0, 39) == 0);
            if (wr_sel == 3'd0) begin
                wr_data = 16'($urandom_range(0, 255));
                if ($urandom_range(0, 3) != 0) wr_data[1] = 1'b0;
            end else if (wr_sel == 3'd2) begin
                wr_data = 16'($urandom_range(0, 2));
            end else begin
                wr_data = 16'($urandom_range(0, 9));
            end
        end
        @(negedge clk);
        wr_en = 1'b0; slave_rst = 1'b0;
        idle(5);
        summary();
    end

endmodule